// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the register side of exception entry for an in-order processor core. When the core decides to take a fault, it raises a one-cycle take strobe together with a vector of fault requests, the program counter of the faulting instruction, the program counter that would have followed it, and the present contents of four privileged registers: status, cause, exception PC and shadow-set control. On the next clock edge the block loads the updated copies of those four registers and the redirect target into its output registers. The core then writes the updated copies back and fetches from the new PC.

The controller picks one request by fixed priority. Reset always wins. It maps the chosen fault to an exception code and a vector offset, and works out whether the faulting instruction sat in a branch delay slot. It switches the shadow register set only when the core was not already at exception level and was not using the bootstrap vectors. Reset entry has its own path: the PC goes to a fixed reset address, the floating-point coprocessor is marked usable, and no other state changes. Soft reset and non-maskable interrupt are not serviced. If one of them is chosen, the block raises an error pulse and leaves every output register untouched.

A small state machine records the result of the last strobe. From `ST_IDLE`, a strobe that selects a serviceable fault moves to `ST_ENTERED`, which drives the done pulse. A strobe that selects soft reset or NMI moves to `ST_REJECTED`, which drives the error pulse. With no strobe, or with a strobe that carries no request, every state returns to `ST_IDLE`. A new strobe may follow straight away from `ST_ENTERED` or `ST_REJECTED`.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all output registers become zero and the state becomes `ST_IDLE`, so `entry_done_o` and `unsup_err_o` are 0.
- R2: When several request bits are set, the lowest bit index wins. The order is: 0 reset, 1 soft reset, 2 NMI, 3 machine check, 4 address error, 5 TLB refill, 6 TLB invalid, 7 TLB modified, 8 coprocessor unusable, 9 reserved instruction, 10 DSP disabled, 11 thread, 12 syscall, 13 breakpoint, 14 overflow, 15 trap, 16 interrupt. Only the winner is serviced.
- R3: For a serviced fault other than reset, `status_o` equals `status_i` with bit 1 (EXL) forced to 1, even if it was already 1. All other status bits are copied.
- R4: For a serviced fault other than reset, if status bit 1 (EXL) and bit 22 (BEV) are both 0, `srsctl_o` takes the current-set field [3:0] into the previous-set field [9:6], and the exception-set field [15:12] into [3:0]. Otherwise `srsctl_o` equals `srsctl_i`.
- R5: The fault is in a delay slot when `next_pc_i != cur_pc_i + 4`. `epc_o` is then `cur_pc_i - 4`; otherwise it is `cur_pc_i`.
- R6: For a serviced fault other than reset, `cause_o` equals `cause_i` except as follows: bit 31 is the delay-slot flag, bits [29:28] are 0, and bits [6:2] hold the code. The codes are: interrupt 0, TLB modified 1, syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, machine check 24, and 0 for every other fault.
- R7: For a serviced fault other than reset, `new_pc_o` = `VEC_BASE` + offset. The offset is 0x000 for interrupt and 0x180 for every other fault.
- R8: For reset, `new_pc_o` = `RESET_BASE` and `status_o` equals `status_i` with bit 29 (coprocessor 1 usable) set. EXL is not changed. `cause_o`, `epc_o` and `srsctl_o` copy their inputs.
- R9: When soft reset or NMI wins, `unsup_err_o` is 1 for exactly the cycle after the strobe, `entry_done_o` stays 0, and no output register changes.
- R10: Without a strobe, or on a strobe with no request bit set, every output register holds its value and both pulses are 0.
- R11: After a strobe that services a fault, `entry_done_o` is 1 for exactly one cycle, the cycle after that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Fault-take strobe |
| fault_req_i | input | 17 | Fault request bits, indexed as in R2 |
| cur_pc_i | input | XLEN | PC of the faulting instruction |
| next_pc_i | input | XLEN | PC that would follow the faulting instruction |
| status_i | input | XLEN | Current status register |
| cause_i | input | XLEN | Current cause register |
| epc_i | input | XLEN | Current exception PC register |
| srsctl_i | input | XLEN | Current shadow-set control register |
| new_pc_o | output | XLEN | Redirect target |
| status_o | output | XLEN | Updated status register |
| cause_o | output | XLEN | Updated cause register |
| epc_o | output | XLEN | Updated exception PC register |
| srsctl_o | output | XLEN | Updated shadow-set control register |
| entry_done_o | output | 1 | One-cycle pulse: a fault was serviced |
| unsup_err_o | output | 1 | One-cycle pulse: an unsupported fault was selected |

## Verification
Each result has a latency of one clock edge from the strobe. The five output registers and both pulses all change at the first rising edge after the cycle in which `take_i` is high. The bench drives a strobe at a falling edge, removes it at the next falling edge, and compares every output there, half a period after the edge that loaded them. It sweeps every fault index against both delay-slot cases and all four EXL/BEV combinations, then checks priority, the unsupported pulse and holding at the same point one edge after each stimulus.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int NUM_FAULTS = 17;
    localparam int FIDX_W     = 5;

    // Status register bit positions
    localparam int ST_EXL_BIT = 1;
    localparam int ST_BEV_BIT = 22;
    localparam int ST_CU1_BIT = 29;

    // Cause register fields
    localparam int CA_BD_BIT  = 31;
    localparam int CA_CE_HI   = 29;
    localparam int CA_CE_LO   = 28;
    localparam int CA_EXC_HI  = 6;
    localparam int CA_EXC_LO  = 2;

    // Shadow-set control fields
    localparam int SS_CUR_LO  = 0;
    localparam int SS_PREV_LO = 6;
    localparam int SS_EXC_LO  = 12;
    localparam int SS_FLD_W   = 4;

    // Fault identifiers, index equals priority (0 highest)
    typedef enum logic [FIDX_W-1:0] {
        F_RESET       = 5'd0,
        F_SOFT_RESET  = 5'd1,
        F_NMI         = 5'd2,
        F_MCHECK      = 5'd3,
        F_ADDR_ERR    = 5'd4,
        F_TLB_REFILL  = 5'd5,
        F_TLB_INVALID = 5'd6,
        F_TLB_MOD     = 5'd7,
        F_CP_UNUSABLE = 5'd8,
        F_RSVD_INSN   = 5'd9,
        F_DSP_OFF     = 5'd10,
        F_THREAD      = 5'd11,
        F_SYSCALL     = 5'd12,
        F_BREAK       = 5'd13,
        F_OVERFLOW    = 5'd14,
        F_TRAP        = 5'd15,
        F_INTERRUPT   = 5'd16
    } fault_e;

    typedef struct packed {
        logic [4:0] code;
        logic       far_vec;
        logic       is_reset;
        logic       is_unsup;
    } fault_attr_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ENTERED  = 2'd1,
        ST_REJECTED = 2'd2
    } entry_state_e;

endpackage

// File: rtl/exc_fault_select.sv
module exc_fault_select
    import exc_entry_pkg::*;
#(
    parameter int N = NUM_FAULTS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output fault_e       sel_o
);

    logic [N:0]   blocked;
    logic [N-1:0] grant;

    assign blocked[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_prio
            assign grant[g]     = req_i[g] & ~blocked[g];
            assign blocked[g+1] = blocked[g] | req_i[g];
        end
    endgenerate

    assign any_o = blocked[N];

    always_comb begin
        logic [FIDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = FIDX_W'(i);
        end
        sel_o = fault_e'(idx);
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2
    grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[0] |-> (sel_o == F_RESET));

endmodule

// File: rtl/exc_fault_map.sv
module exc_fault_map
    import exc_entry_pkg::*;
(
    input  fault_e      sel_i,
    output fault_attr_t attr_o
);

    always_comb begin
        attr_o          = '0;
        attr_o.far_vec  = 1'b1;
        unique case (sel_i)
            F_RESET: begin
                attr_o.is_reset = 1'b1;
                attr_o.far_vec  = 1'b0;
            end
            F_SOFT_RESET, F_NMI: begin
                attr_o.is_unsup = 1'b1;
                attr_o.far_vec  = 1'b0;
            end
            F_INTERRUPT: begin
                attr_o.code    = 5'd0;
                attr_o.far_vec = 1'b0;
            end
            F_TLB_MOD:     attr_o.code = 5'd1;
            F_SYSCALL:     attr_o.code = 5'd8;
            F_BREAK:       attr_o.code = 5'd9;
            F_RSVD_INSN:   attr_o.code = 5'd10;
            F_CP_UNUSABLE: attr_o.code = 5'd11;
            F_OVERFLOW:    attr_o.code = 5'd12;
            F_TRAP:        attr_o.code = 5'd13;
            F_MCHECK:      attr_o.code = 5'd24;
            default:       attr_o.code = 5'd0;
        endcase
    end

endmodule

// File: rtl/exc_reg_update.sv
module exc_reg_update
    import exc_entry_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'h8000_0000,
    parameter logic [XLEN-1:0] RESET_BASE = 32'hBFC0_0000,
    parameter int          INSN_BYTES = 4,
    parameter int          FAR_OFFSET = 'h180
) (
    input  fault_attr_t     attr_i,
    input  logic [XLEN-1:0] cur_pc_i,
    input  logic [XLEN-1:0] next_pc_i,
    input  logic [XLEN-1:0] status_i,
    input  logic [XLEN-1:0] cause_i,
    input  logic [XLEN-1:0] epc_i,
    input  logic [XLEN-1:0] srsctl_i,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] status_o,
    output logic [XLEN-1:0] cause_o,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] srsctl_o,
    output logic            in_slot_o
);

    localparam logic [XLEN-1:0] STEP    = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] OFF_FAR = XLEN'(FAR_OFFSET);

    logic            switch_set;
    logic [XLEN-1:0] srs_switched;

    assign in_slot_o  = (next_pc_i != (cur_pc_i + STEP));
    assign switch_set = ~status_i[ST_EXL_BIT] & ~status_i[ST_BEV_BIT];

    always_comb begin
        srs_switched = srsctl_i;
        srs_switched[SS_PREV_LO +: SS_FLD_W] = srsctl_i[SS_CUR_LO +: SS_FLD_W];
        srs_switched[SS_CUR_LO  +: SS_FLD_W] = srsctl_i[SS_EXC_LO +: SS_FLD_W];
    end

    always_comb begin
        if (attr_i.is_reset) begin
            pc_o                 = RESET_BASE;
            status_o             = status_i;
            status_o[ST_CU1_BIT] = 1'b1;
            cause_o              = cause_i;
            epc_o                = epc_i;
            srsctl_o             = srsctl_i;
        end else begin
            pc_o                 = VEC_BASE + (attr_i.far_vec ? OFF_FAR : '0);
            status_o             = status_i;
            status_o[ST_EXL_BIT] = 1'b1;
            cause_o              = cause_i;
            cause_o[CA_BD_BIT]   = in_slot_o;
            cause_o[CA_CE_HI:CA_CE_LO]   = 2'b00;
            cause_o[CA_EXC_HI:CA_EXC_LO] = attr_i.code;
            epc_o                = in_slot_o ? (cur_pc_i - STEP) : cur_pc_i;
            srsctl_o             = switch_set ? srs_switched : srsctl_i;
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'h8000_0000,
    parameter logic [XLEN-1:0] RESET_BASE = 32'hBFC0_0000,
    parameter int              INSN_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take_i,
    input  logic [NUM_FAULTS-1:0] fault_req_i,
    input  logic [XLEN-1:0]       cur_pc_i,
    input  logic [XLEN-1:0]       next_pc_i,
    input  logic [XLEN-1:0]       status_i,
    input  logic [XLEN-1:0]       cause_i,
    input  logic [XLEN-1:0]       epc_i,
    input  logic [XLEN-1:0]       srsctl_i,
    output logic [XLEN-1:0]       new_pc_o,
    output logic [XLEN-1:0]       status_o,
    output logic [XLEN-1:0]       cause_o,
    output logic [XLEN-1:0]       epc_o,
    output logic [XLEN-1:0]       srsctl_o,
    output logic                  entry_done_o,
    output logic                  unsup_err_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic        any_req;
    fault_e      sel;
    fault_attr_t attr;
    logic        service, reject, in_slot;

    logic [XLEN-1:0] nx_pc, nx_status, nx_cause, nx_epc, nx_srsctl;
    logic [XLEN-1:0] pc_q, status_q, cause_q, epc_q, srsctl_q;

    entry_state_e state_q, state_d;

    exc_fault_select #(.N(NUM_FAULTS)) u_select (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (fault_req_i),
        .any_o (any_req),
        .sel_o (sel)
    );

    exc_fault_map u_map (
        .sel_i  (sel),
        .attr_o (attr)
    );

    exc_reg_update #(
        .XLEN       (XLEN),
        .VEC_BASE   (VEC_BASE),
        .RESET_BASE (RESET_BASE),
        .INSN_BYTES (INSN_BYTES)
    ) u_update (
        .attr_i    (attr),
        .cur_pc_i  (cur_pc_i),
        .next_pc_i (next_pc_i),
        .status_i  (status_i),
        .cause_i   (cause_i),
        .epc_i     (epc_i),
        .srsctl_i  (srsctl_i),
        .pc_o      (nx_pc),
        .status_o  (nx_status),
        .cause_o   (nx_cause),
        .epc_o     (nx_epc),
        .srsctl_o  (nx_srsctl),
        .in_slot_o (in_slot)
    );

    assign service = take_i & any_req & ~attr.is_unsup;
    assign reject  = take_i & any_req &  attr.is_unsup;

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ENTERED, ST_REJECTED: begin
                if (service)     state_d = ST_ENTERED;
                else if (reject) state_d = ST_REJECTED;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Architectural output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            status_q <= '0;
            cause_q  <= '0;
            epc_q    <= '0;
            srsctl_q <= '0;
        end else if (service) begin
            pc_q     <= nx_pc;
            status_q <= nx_status;
            cause_q  <= nx_cause;
            epc_q    <= nx_epc;
            srsctl_q <= nx_srsctl;
        end
    end

    // Output decode from state
    always_comb begin
        entry_done_o = 1'b0;
        unsup_err_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_ENTERED:  entry_done_o = 1'b1;
            ST_REJECTED: unsup_err_o  = 1'b1;
            default:     ;
        endcase
    end

    assign new_pc_o = pc_q;
    assign status_o = status_q;
    assign cause_o  = cause_q;
    assign epc_o    = epc_q;
    assign srsctl_o = srsctl_q;

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!entry_done_o && !unsup_err_o && new_pc_o == '0));

    // R3
    exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (service && !attr.is_reset) |=> status_o[ST_EXL_BIT]);

    // R5
    epc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (service && !attr.is_reset && next_pc_i != cur_pc_i + STEP)
        |=> (epc_o == $past(cur_pc_i) - STEP));

    // R8
    reset_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && fault_req_i[0]) |=> (new_pc_o == RESET_BASE && status_o[ST_CU1_BIT]));

    // R9
    unsup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (unsup_err_o && !entry_done_o && $stable(new_pc_o) && $stable(epc_o)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> ($stable(new_pc_o) && $stable(status_o) && $stable(cause_o)
                     && !entry_done_o && !unsup_err_o));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        service |=> entry_done_o ##1 (!entry_done_o || $past(service)));

endmodule

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;

    localparam int          XLEN = 32;
    localparam logic [31:0] VEC  = 32'h8000_0000;
    localparam logic [31:0] RST  = 32'hBFC0_0000;
    localparam int          NF   = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          take = 1'b0;
    logic [NF-1:0] req = '0;
    logic [31:0]   cur_pc = '0, nxt_pc = '0, st_in = '0, ca_in = '0, ep_in = '0, ss_in = '0;
    logic [31:0]   pc_o, st_o, ca_o, ep_o, ss_o;
    logic          done_o, unsup_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // expected model state
    logic [31:0] e_pc = '0, e_st = '0, e_ca = '0, e_ep = '0, e_ss = '0;

    always #4 clk = ~clk;

    exc_entry_ctrl #(.XLEN(XLEN), .VEC_BASE(VEC), .RESET_BASE(RST), .INSN_BYTES(4)) i_exc_entry_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (take),
        .fault_req_i  (req),
        .cur_pc_i     (cur_pc),
        .next_pc_i    (nxt_pc),
        .status_i     (st_in),
        .cause_i      (ca_in),
        .epc_i        (ep_in),
        .srsctl_i     (ss_in),
        .new_pc_o     (pc_o),
        .status_o     (st_o),
        .cause_o      (ca_o),
        .epc_o        (ep_o),
        .srsctl_o     (ss_o),
        .entry_done_o (done_o),
        .unsup_err_o  (unsup_o)
    );

    task automatic chk(string req_tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req_tag, what, act, exp);
        end
    endtask

    function automatic logic [4:0] code_of(int f);
        case (f)
            16: return 5'd0;
            7:  return 5'd1;
            12: return 5'd8;
            13: return 5'd9;
            9:  return 5'd10;
            8:  return 5'd11;
            14: return 5'd12;
            15: return 5'd13;
            3:  return 5'd24;
            default: return 5'd0;
        endcase
    endfunction

    // Apply one strobe and check all outputs one edge later
    task automatic strobe(logic [NF-1:0] r, logic [31:0] cp, logic [31:0] np,
                          logic [31:0] s, logic [31:0] c, logic [31:0] e, logic [31:0] ss,
                          string tag);
        int  win;
        bit  ds;
        logic exp_done, exp_unsup;
        string pc_tag, st_tag;
        win = -1;
        for (int i = NF - 1; i >= 0; i--) if (r[i]) win = i;
        req = r; cur_pc = cp; nxt_pc = np; st_in = s; ca_in = c; ep_in = e; ss_in = ss;
        take = 1'b1;
        @(negedge clk);
        take = 1'b0;
        exp_done = 1'b0; exp_unsup = 1'b0;
        pc_tag = "R7"; st_tag = "R3";
        if (win == 1 || win == 2) begin
            exp_unsup = 1'b1;
        end else if (win == 0) begin
            exp_done = 1'b1;
            pc_tag = "R8"; st_tag = "R8";
            e_pc = RST; e_st = s | 32'h2000_0000; e_ca = c; e_ep = e; e_ss = ss;
        end else if (win > 2) begin
            exp_done = 1'b1;
            ds = (np != cp + 32'd4);
            e_st = s | 32'h0000_0002;
            e_ss = ss;
            if (!s[1] && !s[22]) begin
                e_ss[9:6] = ss[3:0];
                e_ss[3:0] = ss[15:12];
            end
            e_ep = ds ? cp - 32'd4 : cp;
            e_ca = c;
            e_ca[31] = ds;
            e_ca[29:28] = 2'b00;
            e_ca[6:2] = code_of(win);
            e_pc = VEC + ((win == 16) ? 32'h0 : 32'h180);
        end
        chk({tag, " R11"}, "done", {31'd0, done_o}, {31'd0, exp_done});
        chk({tag, " R9"},  "unsup", {31'd0, unsup_o}, {31'd0, exp_unsup});
        chk({tag, " ", pc_tag}, "pc", pc_o, e_pc);
        chk({tag, " ", st_tag}, "status", st_o, e_st);
        chk({tag, " R6"},  "cause", ca_o, e_ca);
        chk({tag, " R5"},  "epc", ep_o, e_ep);
        chk({tag, " R4"},  "srsctl", ss_o, e_ss);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] s, cp;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "pc", pc_o, 32'h0);
        chk("R1", "status", st_o, 32'h0);
        chk("R1", "done", {31'd0, done_o}, 32'h0);
        chk("R1", "unsup", {31'd0, unsup_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: every fault x delay-slot x EXL/BEV (R3..R9, R11)
        for (int f = 0; f < NF; f++) begin
            for (int d = 0; d < 2; d++) begin
                for (int eb = 0; eb < 4; eb++) begin
                    s  = 32'h0010_FF00 | (eb[0] ? 32'h2 : 32'h0) | (eb[1] ? 32'h0040_0000 : 32'h0);
                    cp = 32'h0040_1000 + 32'(f * 64 + d * 16 + eb * 4);
                    strobe(NF'(1) << f, cp, d ? cp + 32'd100 : cp + 32'd4, s,
                           32'hA5A5_5A5A ^ 32'(f << 8), 32'hDEAD_0000 + 32'(f), 32'h0000_9285,
                           "sweep");
                end
            end
        end

        // R2 priority with several requests
        strobe(17'h1FFFF, 32'h100, 32'h104, 32'h0, 32'h0, 32'h55, 32'h9285, "R2 all");
        strobe(17'h10000 | 17'h01000, 32'h200, 32'h204, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h9285, "R2 int+sys");
        strobe(17'h0A000 | 17'h00008, 32'h300, 32'h380, 32'h2, 32'h0, 32'h0, 32'h1234, "R2 trap+bp+mchk");
        strobe(17'h00004 | 17'h00100, 32'h400, 32'h404, 32'h0, 32'h0, 32'h0, 32'h9285, "R2 nmi+cpu");
        strobe(17'h00080 | 17'h00200, 32'h500, 32'h504, 32'h0, 32'h0, 32'h0, 32'h9285, "R2 tlbmod+ri");

        // R10 hold without strobe
        req = 17'h01000; cur_pc = 32'h9999_0000; nxt_pc = 32'h0; st_in = 32'hFFFF_FFFF;
        @(negedge clk);
        chk("R10", "pc", pc_o, e_pc);
        chk("R10", "status", st_o, e_st);
        chk("R10", "epc", ep_o, e_ep);
        chk("R10", "done", {31'd0, done_o}, 32'h0);
        // R10 strobe with no request
        strobe('0, 32'h7777_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, "R10 empty");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule